// File: doc/BRIEF.md
# Reference-Level Correction Decoder

A successive-approximation converter whose reference ladder has mismatched steps produces raw codes that no longer sit on evenly spaced levels. This block turns each raw code into the true level it stands for. It does this with a table of per-step relative errors supplied by an external estimator. Each error term gives, in units of one nominal step, how far the spacing between one reference level and the level below it is off. The corrected level for code k is k plus the running sum of the first k error terms. Code 0 is ground and always maps to zero. The result is a fixed-point value with CODE_W integer bits and FRAC_W fraction bits.

The estimator writes error terms one at a time through a write port and then pulses a commit strobe. Writing alone changes nothing at the output. On commit, the block walks the parameter vector one level per clock and builds the cumulative-sum table into a second, inactive bank. While it does so, it keeps answering codes from the active bank. When the last entry has been written, the two banks swap in a single step. Until the first commit completes, no table is used and the output is simply the raw code in fixed-point form.

Top module: `level_corrector`

## Requirements
- R1: While reset is held and after it, `lvl_vld` is low and `lvl` is zero. Until the first rebuild completes, each code k gives `lvl` = k·2^FRAC_W, meaning the code sits in the integer bits and the fraction is zero.
- R2: `lvl_vld` is high exactly one clock after each cycle in which `code_vld` is sampled high. It is low one clock after a cycle in which `code_vld` is sampled low.
- R3: Code 0 always gives `lvl` = 0, whatever parameters are loaded.
- R4: After a rebuild, code k (k ≥ 1) gives `lvl` = k·2^FRAC_W + θ1 + … + θk. Here θi is the last `prm_val` written with `prm_idx` = i before the commit, read as a two's-complement number with FRAC_W fraction bits.
- R5: A corrected value below zero is output as 0. A corrected value above 2^(CODE_W+FRAC_W) − 1 is output as all ones.
- R6: Parameter writes on their own never change `lvl`. Take a commit sampled at clock edge E. Codes sampled at edges up to and including E + 2^CODE_W are answered from the previous table. Codes sampled from edge E + 2^CODE_W + 1 onward are answered from the new table.
- R7: A write with `prm_idx` = 0 has no effect on any later output.
- R8: A commit sampled while a rebuild is running restarts the rebuild from level 0. The previous table keeps being served until 2^CODE_W + 1 edges after the last commit. The resulting table uses the parameters as they stand during the restarted pass.
- R9: `lvl` holds its value through cycles in which `code_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| code_vld | input | 1 | Raw code valid |
| code | input | CODE_W | Raw converter code |
| prm_we | input | 1 | Error-term write enable |
| prm_idx | input | CODE_W | Level index of the error term (1 to 2^CODE_W − 1) |
| prm_val | input | PARAM_W | Signed error term, FRAC_W fraction bits |
| prm_commit | input | 1 | Strobe: rebuild the table from the current error terms |
| lvl_vld | output | 1 | Corrected level valid |
| lvl | output | CODE_W+FRAC_W | Corrected level, CODE_W integer bits and FRAC_W fraction bits |

## Verification
The bench builds the block with CODE_W = 4, FRAC_W = 12 and PARAM_W = 16. Sixteen levels let every code be swept after every parameter load. A rebuild then lasts only sixteen clocks, so one unbroken sweep straddles the bank swap and shows the exact edge at which the new table takes over. Error terms with four integer bits can push the running sum past both ends of the 16-bit output range, which exercises saturation at zero and at full scale. The short rebuild also leaves room to write a parameter behind the builder's position and restart it with a second commit.

// File: rtl/lc_pkg.sv
package lc_pkg;

  // Which source answers incoming codes.
  typedef enum logic [1:0] {
    SRC_IDENT = 2'd0,
    SRC_BANK0 = 2'd1,
    SRC_BANK1 = 2'd2
  } src_e;

  // Table builder sequencer state.
  typedef enum logic {
    BLD_IDLE = 1'b0,
    BLD_RUN  = 1'b1
  } bld_e;

endpackage

// File: rtl/lc_param_file.sv
module lc_param_file #(
  parameter int CODE_W  = 8,
  parameter int PARAM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CODE_W-1:0]         wr_idx,
  input  logic signed [PARAM_W-1:0] wr_val,
  input  logic [CODE_W-1:0]         rd_idx,
  output logic signed [PARAM_W-1:0] rd_val
);

  localparam int NLVL = 1 << CODE_W;

  logic signed [PARAM_W-1:0] term_vec [NLVL];

  // Level 0 is ground: no error term is stored for it.
  assign term_vec[0] = '0;

  for (genvar gi = 1; gi < NLVL; gi++) begin : g_term
    logic signed [PARAM_W-1:0] term_q;
    logic signed [PARAM_W-1:0] term_d;
    logic                      term_en;

    always_comb begin
      term_en = wr_en && (wr_idx == CODE_W'(gi));
      term_d  = term_en ? wr_val : term_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        term_q <= '0;
      end else begin
        term_q <= term_d;
      end
    end

    assign term_vec[gi] = term_q;
  end

  assign rd_val = term_vec[rd_idx];

endmodule

// File: rtl/lc_level_table.sv
module lc_level_table #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int NBANK = 2;

  logic [DATA_W-1:0] bank_rd [NBANK];

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic              bank_we;

    assign bank_we = wr_en && (wr_bank == 1'(gb));

    // Storage array: contents are always written before the bank is selected.
    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign bank_rd[gb] = mem[rd_addr];
  end

  assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/lc_table_builder.sv
module lc_table_builder
  import lc_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int FRAC_W  = 12,
  parameter int PARAM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  output logic [CODE_W-1:0]         prm_idx,
  input  logic signed [PARAM_W-1:0] prm_val,
  output logic                      tw_en,
  output logic                      tw_bank,
  output logic [CODE_W-1:0]         tw_addr,
  output logic [CODE_W+FRAC_W-1:0]  tw_data,
  output src_e                      rd_src
);

  localparam int OUT_W = CODE_W + FRAC_W;
  // Enough headroom for 2^CODE_W steps of (1 + largest term).
  localparam int ACC_W = CODE_W + PARAM_W + 2;
  localparam logic [CODE_W-1:0]       LAST_IDX = {CODE_W{1'b1}};
  localparam logic signed [ACC_W-1:0] ONE_STEP = ACC_W'(1) << FRAC_W;
  localparam logic signed [ACC_W-1:0] MAX_LVL  = (ACC_W'(1) << OUT_W) - ACC_W'(1);

  bld_e                      st_q,  st_d;
  logic [CODE_W-1:0]         idx_q, idx_d;
  logic signed [ACC_W-1:0]   acc_q, acc_d;
  logic                      dst_q, dst_d;
  src_e                      src_q, src_d;

  logic signed [ACC_W-1:0]   term_ext;
  logic signed [ACC_W-1:0]   level_sum;
  logic [OUT_W-1:0]          level_sat;

  // Running sum of nominal steps plus error terms.
  always_comb begin
    term_ext = {{(ACC_W-PARAM_W){prm_val[PARAM_W-1]}}, prm_val};
    if (idx_q == '0) begin
      level_sum = '0;
    end else begin
      level_sum = acc_q + ONE_STEP + term_ext;
    end
  end

  // Saturate into the unsigned output range.
  always_comb begin
    if (level_sum < 0) begin
      level_sat = '0;
    end else if (level_sum > MAX_LVL) begin
      level_sat = '1;
    end else begin
      level_sat = level_sum[OUT_W-1:0];
    end
  end

  // Sequencer next state.
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    acc_d = acc_q;
    dst_d = dst_q;
    src_d = src_q;
    if (commit) begin
      st_d  = BLD_RUN;
      idx_d = '0;
      acc_d = '0;
      dst_d = (src_q == SRC_BANK0);
    end else if (st_q == BLD_RUN) begin
      acc_d = level_sum;
      idx_d = idx_q + CODE_W'(1);
      if (idx_q == LAST_IDX) begin
        st_d  = BLD_IDLE;
        src_d = dst_q ? SRC_BANK1 : SRC_BANK0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BLD_IDLE;
      idx_q <= '0;
      acc_q <= '0;
      dst_q <= 1'b0;
      src_q <= SRC_IDENT;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      acc_q <= acc_d;
      dst_q <= dst_d;
      src_q <= src_d;
    end
  end

  assign prm_idx = idx_q;
  assign tw_en   = (st_q == BLD_RUN);
  assign tw_bank = dst_q;
  assign tw_addr = idx_q;
  assign tw_data = level_sat;
  assign rd_src  = src_q;

endmodule

// File: rtl/lc_lookup.sv
module lc_lookup
  import lc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     code_vld,
  input  logic [CODE_W-1:0]        code,
  input  src_e                     src,
  input  logic [CODE_W+FRAC_W-1:0] tbl_data,
  output logic                     lvl_vld,
  output logic [CODE_W+FRAC_W-1:0] lvl
);

  localparam int OUT_W = CODE_W + FRAC_W;

  logic             vld_q, vld_d;
  logic [OUT_W-1:0] lvl_q, lvl_d;
  logic [OUT_W-1:0] pick;

  always_comb begin
    if (src == SRC_IDENT) begin
      pick = {code, {FRAC_W{1'b0}}};
    end else begin
      pick = tbl_data;
    end
    vld_d = code_vld;
    lvl_d = code_vld ? pick : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      vld_q <= vld_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_vld = vld_q;
  assign lvl     = lvl_q;

endmodule

// File: rtl/level_corrector.sv
module level_corrector
  import lc_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int FRAC_W  = 12,
  parameter int PARAM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      code_vld,
  input  logic [CODE_W-1:0]         code,
  input  logic                      prm_we,
  input  logic [CODE_W-1:0]         prm_idx,
  input  logic signed [PARAM_W-1:0] prm_val,
  input  logic                      prm_commit,
  output logic                      lvl_vld,
  output logic [CODE_W+FRAC_W-1:0]  lvl
);

  localparam int OUT_W = CODE_W + FRAC_W;

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [CODE_W-1:0]         bld_idx;
  logic signed [PARAM_W-1:0] bld_term;
  logic                      tw_en;
  logic                      tw_bank;
  logic [CODE_W-1:0]         tw_addr;
  logic [OUT_W-1:0]          tw_data;
  src_e                      rd_src;
  logic [OUT_W-1:0]          tbl_rd;

  lc_param_file #(
    .CODE_W (CODE_W),
    .PARAM_W(PARAM_W)
  ) u_prm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (prm_we),
    .wr_idx(prm_idx),
    .wr_val(prm_val),
    .rd_idx(bld_idx),
    .rd_val(bld_term)
  );

  lc_table_builder #(
    .CODE_W (CODE_W),
    .FRAC_W (FRAC_W),
    .PARAM_W(PARAM_W)
  ) u_bld (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .commit (prm_commit),
    .prm_idx(bld_idx),
    .prm_val(bld_term),
    .tw_en  (tw_en),
    .tw_bank(tw_bank),
    .tw_addr(tw_addr),
    .tw_data(tw_data),
    .rd_src (rd_src)
  );

  lc_level_table #(
    .ADDR_W(CODE_W),
    .DATA_W(OUT_W)
  ) u_tbl (
    .clk    (clk),
    .wr_en  (tw_en),
    .wr_bank(tw_bank),
    .wr_addr(tw_addr),
    .wr_data(tw_data),
    .rd_bank(rd_src == SRC_BANK1),
    .rd_addr(code),
    .rd_data(tbl_rd)
  );

  lc_lookup #(
    .CODE_W(CODE_W),
    .FRAC_W(FRAC_W)
  ) u_lkp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .code_vld(code_vld),
    .code    (code),
    .src     (rd_src),
    .tbl_data(tbl_rd),
    .lvl_vld (lvl_vld),
    .lvl     (lvl)
  );

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int CODE_W = 8,
  parameter int FRAC_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     code_vld,
  input logic [CODE_W-1:0]        code,
  input logic                     prm_commit,
  input logic                     lvl_vld,
  input logic [CODE_W+FRAC_W-1:0] lvl
);

  logic seen_commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_commit_q <= 1'b0;
    end else if (prm_commit) begin
      seen_commit_q <= 1'b1;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |=> lvl_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld |=> !lvl_vld);

  // R3
  ground_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && (code == '0)) |=> (lvl == '0));

  // R9
  hold_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld |=> $stable(lvl));

  // R1
  ident_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && !seen_commit_q && !prm_commit) |=>
      (lvl == {$past(code), {FRAC_W{1'b0}}}));

endmodule

bind level_corrector lc_checker #(
  .CODE_W(CODE_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .code_vld  (code_vld),
  .code      (code),
  .prm_commit(prm_commit),
  .lvl_vld   (lvl_vld),
  .lvl       (lvl)
);

// File: tb/tb_level_corrector.sv
module tb_level_corrector;

  localparam int CW   = 4;
  localparam int FW   = 12;
  localparam int PW   = 16;
  localparam int NL   = 1 << CW;
  localparam int ONE  = 1 << FW;
  localparam int MAXL = (1 << (CW + FW)) - 1;

  logic                 clk;
  logic                 rst_n;
  logic                 code_vld;
  logic [CW-1:0]        code;
  logic                 prm_we;
  logic [CW-1:0]        prm_idx;
  logic signed [PW-1:0] prm_val;
  logic                 prm_commit;
  logic                 lvl_vld;
  logic [CW+FW-1:0]     lvl;

  level_corrector #(
    .CODE_W (CW),
    .FRAC_W (FW),
    .PARAM_W(PW)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_vld  (code_vld),
    .code      (code),
    .prm_we    (prm_we),
    .prm_idx   (prm_idx),
    .prm_val   (prm_val),
    .prm_commit(prm_commit),
    .lvl_vld   (lvl_vld),
    .lvl       (lvl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int          n_chk;
  int          n_fail;
  int          tbl_cur [NL];
  int          tbl_new [NL];
  int          th_wr   [NL];
  logic [15:0] lf;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected table from the written error terms (R4, R5).
  task automatic build_model();
    int acc;
    acc = 0;
    tbl_new[0] = 0;
    for (int k = 1; k < NL; k++) begin
      acc = acc + ONE + th_wr[k];
      if (acc < 0) tbl_new[k] = 0;
      else if (acc > MAXL) tbl_new[k] = MAXL;
      else tbl_new[k] = acc;
    end
  endtask

  task automatic wr_term(input int idx, input int val);
    @(negedge clk);
    prm_we  = 1'b1;
    prm_idx = CW'(idx);
    prm_val = PW'(val);
    if (idx != 0) th_wr[idx] = val;
    @(negedge clk);
    prm_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    prm_commit = 1'b1;
    @(negedge clk);
    prm_commit = 1'b0;
  endtask

  // Back-to-back codes; index j >= first_new expects the new table.
  task automatic sweep(input int n, input int first_new, input string req);
    int prev_exp;
    int prev_code;
    prev_exp  = 0;
    prev_code = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (j > 0) begin
        chk(lvl_vld == 1'b1, "R2", int'(lvl_vld), 1);
        chk(int'(lvl) == prev_exp, (prev_code == 0) ? "R3" : req, int'(lvl), prev_exp);
      end
      code_vld  = 1'b1;
      code      = CW'(j % NL);
      prev_code = j % NL;
      prev_exp  = (j >= first_new) ? tbl_new[j % NL] : tbl_cur[j % NL];
    end
    @(negedge clk);
    chk(lvl_vld == 1'b1, "R2", int'(lvl_vld), 1);
    chk(int'(lvl) == prev_exp, (prev_code == 0) ? "R3" : req, int'(lvl), prev_exp);
    code_vld = 1'b0;
    @(negedge clk);
    chk(lvl_vld == 1'b0, "R2", int'(lvl_vld), 0);
    @(negedge clk);
    chk(int'(lvl) == prev_exp, "R9", int'(lvl), prev_exp);
  endtask

  task automatic lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    n_chk      = 0;
    n_fail     = 0;
    lf         = 16'hACE1;
    rst_n      = 1'b0;
    code_vld   = 1'b0;
    code       = '0;
    prm_we     = 1'b0;
    prm_idx    = '0;
    prm_val    = '0;
    prm_commit = 1'b0;
    for (int k = 0; k < NL; k++) begin
      th_wr[k]   = 0;
      tbl_cur[k] = k * ONE;
      tbl_new[k] = k * ONE;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lvl_vld == 1'b0, "R1", int'(lvl_vld), 0);
    chk(int'(lvl) == 0, "R1", int'(lvl), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(lvl_vld == 1'b0, "R1", int'(lvl_vld), 0);

    // Identity mapping before any rebuild.
    sweep(NL, 1000, "R1");

    // Pseudo-random error vectors.
    for (int r = 0; r < 4; r++) begin
      for (int k = 1; k < NL; k++) begin
        lf_step();
        wr_term(k, int'(lf[12:0]) - 4096);
      end
      sweep(NL, 1000, "R6");
      build_model();
      commit();
      sweep(2 * NL, NL - 1, (r == 0) ? "R6" : "R4");
      tbl_cur = tbl_new;
    end

    // Saturation at full scale: every term +7.0.
    for (int k = 1; k < NL; k++) wr_term(k, 7 * ONE);
    build_model();
    commit();
    sweep(2 * NL, NL - 1, "R5");
    tbl_cur = tbl_new;

    // Saturation at zero: every term -2.0.
    for (int k = 1; k < NL; k++) wr_term(k, -2 * ONE);
    build_model();
    commit();
    sweep(2 * NL, NL - 1, "R5");
    tbl_cur = tbl_new;

    // Mixed terms, then a write to the ground index.
    for (int k = 1; k < NL; k++) wr_term(k, (k % 2 == 1) ? 1000 : -700);
    build_model();
    commit();
    sweep(2 * NL, NL - 1, "R4");
    tbl_cur = tbl_new;
    wr_term(0, 12345);
    build_model();
    commit();
    sweep(2 * NL, NL - 1, "R7");
    tbl_cur = tbl_new;

    // Restart: write an already-built index mid-rebuild, commit again.
    wr_term(2, 3000);
    commit();
    repeat (6) @(negedge clk);
    wr_term(1, -1500);
    build_model();
    commit();
    sweep(2 * NL, NL - 1, "R8");
    tbl_cur = tbl_new;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule